// File: doc/BRIEF.md
# Converter Channel-0 Input Selection Sequencer

This block decides which analog inputs feed channel 0 of a sampling converter for each sample. It produces a 5-bit positive input index and a 1-bit negative input select. Both are registered, and the multiplexer outside the block uses them for the next sample. Three modes are available:

- **Fixed pair:** every sample uses configuration pair A.
- **Alternation:** samples alternate between pair A and pair B.
- **Scanning:** the positive input of the A slots walks upward through the set bits of a 32-bit input mask. Scanning combines with alternation, in which case the B slots stay on the fixed pair B.

The sequencer advances on a per-sample strobe. In simultaneous-sampling mode every strobe advances it. In sequential mode only strobes that sample channel 0 advance it. An interrupt-boundary pulse sends the scan back to the lowest selected input. When the mask selects more inputs than there are samples between interrupts, the upper inputs are never visited.

Two small state machines hold the sequence.

- **Slot machine:** has states `PH_A` and `PH_B`.
  - `PH_A -> PH_B` and `PH_B -> PH_A` on an advancing strobe while alternation is enabled.
  - Any state goes to `PH_A` when alternation is disabled or on reset.
- **Scan machine:** has states `SC_HOME` (the next A slot takes the lowest selected input) and `SC_WALK` (the next A slot takes the stored pointer).
  - `SC_HOME -> SC_WALK` when an A slot is consumed during scanning; the pointer is loaded with the next selected input above the current one.
  - `SC_WALK -> SC_WALK` on each later consumed A slot; the pointer moves up.
  - Any state goes to `SC_HOME` on an interrupt pulse, when scanning is disabled, or on reset.

Top module: `ch0_input_sequencer`

## Requirements
- R1: With alternation and scanning both disabled, every selection presents `cfg_pos_a` and `cfg_neg_a`, and strobes change nothing.
- R2: With alternation enabled, the first selection is pair A, the next is pair B, and the A/B pattern repeats on each advancing strobe. `sel_is_b` is 1 exactly when pair B is presented.
- R3: With scanning enabled, the A-slot positive index comes from the mask and `cfg_pos_a` is ignored. The mask is `{cfg_mask_hi, cfg_mask_lo}`, so mask bit i selects input i (input 16+j is `cfg_mask_hi` bit j).
- R4: Scanning visits selected inputs from lowest to highest. After the highest selected input, the next A slot wraps to the lowest selected input.
- R5: During scanning, the negative select of A slots is still `cfg_neg_a`.
- R6: With alternation and scanning both enabled, only A slots advance the scan. B slots present `cfg_pos_b` and `cfg_neg_b`.
- R7: With `cfg_simul`=1 every strobe advances the sequence. With `cfg_simul`=0 only a strobe with `smp_ch0`=1 advances it.
- R8: An `irq_evt` pulse makes the next A slot use the lowest selected input. When the pulse coincides with an advancing strobe, the restart wins over the scan step.
- R9: With scanning enabled and an all-zero mask, the A-slot positive index is 0.
- R10: Clearing alternation returns the slot machine to A. Clearing scanning returns the scan to the lowest selected input.
- R11: A synchronous reset drives `sel_pos`=0, `sel_neg`=0 and `sel_is_b`=0. Outputs change on the rising edge after the edge that samples a strobe or a configuration change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pos_a | input | 5 | Pair A positive index |
| cfg_neg_a | input | 1 | Pair A negative select |
| cfg_pos_b | input | 5 | Pair B positive index |
| cfg_neg_b | input | 1 | Pair B negative select |
| cfg_alt_en | input | 1 | Enable A/B alternation |
| cfg_scan_en | input | 1 | Enable mask scanning of the A positive input |
| cfg_simul | input | 1 | 1: simultaneous sampling, 0: sequential |
| cfg_mask_hi | input | 16 | Scan mask, inputs 31..16 |
| cfg_mask_lo | input | 16 | Scan mask, inputs 15..0 |
| smp_stb | input | 1 | One pulse per sample |
| smp_ch0 | input | 1 | This sample is channel 0 |
| irq_evt | input | 1 | Interrupt-period boundary pulse |
| sel_pos | output | 5 | Registered positive input index |
| sel_neg | output | 1 | Registered negative input select |
| sel_is_b | output | 1 | Registered: pair B is presented |

## Verification
The scan step and the interrupt restart can fall in the same cycle: an advancing strobe that consumes an A slot arrives together with `irq_evt`. The bench provokes this with the pointer in the middle of the list, where a lost restart would show the next higher input. It judges the case by requiring the following A slot to show the lowest selected input. It also provokes an interrupt without a strobe, and strobes during B slots, to show that neither moves the scan pointer.

// File: rtl/ch0seq_pkg.sv
package ch0seq_pkg;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    typedef enum logic {
        SC_HOME = 1'b0,
        SC_WALK = 1'b1
    } scan_e;

endpackage

// File: rtl/ch0seq_bitfind.sv
// Finds the lowest set mask bit overall and the lowest set bit strictly
// above a given index; the latter wraps to the former when none exists.
module ch0seq_bitfind #(
    parameter int IDX_W  = 5,
    parameter int MASK_W = 32
) (
    input  logic [MASK_W-1:0] mask,
    input  logic [IDX_W-1:0]  from,
    output logic              any,
    output logic [IDX_W-1:0]  low_idx,
    output logic [IDX_W-1:0]  next_idx
);

    logic [MASK_W-1:0] above;
    logic              found_above;
    logic [IDX_W-1:0]  above_idx;

    generate
        for (genvar i = 0; i < MASK_W; i++) begin : g_above
            assign above[i] = mask[i] && (IDX_W'(i) > from);
        end
    endgenerate

    always_comb begin
        low_idx = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                low_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        above_idx = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (above[i]) begin
                above_idx = IDX_W'(i);
            end
        end
    end

    assign any         = |mask;
    assign found_above = |above;
    assign next_idx    = found_above ? above_idx : low_idx;

endmodule

// File: rtl/ch0seq_phase_fsm.sv
// A/B slot machine.
module ch0seq_phase_fsm
    import ch0seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alt_en,
    input  logic   adv,
    output phase_e phase
);

    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_A;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!alt_en) begin
            state_d = PH_A;
        end else begin
            unique case (state_q)
                PH_A:    if (adv) state_d = PH_B;
                PH_B:    if (adv) state_d = PH_A;
                default: state_d = PH_A;
            endcase
        end
    end

    assign phase = state_q;

endmodule

// File: rtl/ch0seq_scan_fsm.sv
// Scan pointer machine for the A-slot positive input.
module ch0seq_scan_fsm
    import ch0seq_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              step,
    input  logic              restart,
    input  logic [MASK_W-1:0] mask,
    output logic [IDX_W-1:0]  scan_pos
);

    scan_e             state_q;
    scan_e             state_d;
    logic [IDX_W-1:0]  ptr_q;
    logic [IDX_W-1:0]  ptr_d;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  low_idx;
    logic [IDX_W-1:0]  next_idx;
    logic              any_set;

    assign cur_idx = (state_q == SC_HOME) ? low_idx : ptr_q;

    ch0seq_bitfind #(
        .IDX_W  (IDX_W),
        .MASK_W (MASK_W)
    ) u_find (
        .mask     (mask),
        .from     (cur_idx),
        .any      (any_set),
        .low_idx  (low_idx),
        .next_idx (next_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SC_HOME;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (!scan_en || restart) begin
            state_d = SC_HOME;
        end else begin
            unique case (state_q)
                SC_HOME: begin
                    if (step) begin
                        state_d = SC_WALK;
                        ptr_d   = next_idx;
                    end
                end
                SC_WALK: begin
                    if (step) begin
                        ptr_d = next_idx;
                    end
                end
                default: state_d = SC_HOME;
            endcase
        end
    end

    assign scan_pos = any_set ? cur_idx : '0;

endmodule

// File: rtl/ch0seq_outreg.sv
// Selects the presented pair and registers it.
module ch0seq_outreg #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_b,
    input  logic             scan_en,
    input  logic [IDX_W-1:0] pos_a,
    input  logic             neg_a,
    input  logic [IDX_W-1:0] pos_b,
    input  logic             neg_b,
    input  logic [IDX_W-1:0] scan_pos,
    output logic [IDX_W-1:0] out_pos,
    output logic             out_neg,
    output logic             out_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_pos <= '0;
            out_neg <= 1'b0;
            out_b   <= 1'b0;
        end else if (slot_b) begin
            out_pos <= pos_b;
            out_neg <= neg_b;
            out_b   <= 1'b1;
        end else begin
            out_pos <= scan_en ? scan_pos : pos_a;
            out_neg <= neg_a;
            out_b   <= 1'b0;
        end
    end

endmodule

// File: rtl/ch0_input_sequencer.sv
module ch0_input_sequencer
    import ch0seq_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      cfg_pos_a,
    input  logic                  cfg_neg_a,
    input  logic [IDX_W-1:0]      cfg_pos_b,
    input  logic                  cfg_neg_b,
    input  logic                  cfg_alt_en,
    input  logic                  cfg_scan_en,
    input  logic                  cfg_simul,
    input  logic [(1<<IDX_W)/2-1:0] cfg_mask_hi,
    input  logic [(1<<IDX_W)/2-1:0] cfg_mask_lo,
    input  logic                  smp_stb,
    input  logic                  smp_ch0,
    input  logic                  irq_evt,
    output logic [IDX_W-1:0]      sel_pos,
    output logic                  sel_neg,
    output logic                  sel_is_b
);

    localparam int MASK_W = 1 << IDX_W;

    logic [MASK_W-1:0] mask;
    logic              adv;
    logic              slot_b;
    logic              scan_step;
    logic [IDX_W-1:0]  scan_pos;
    phase_e            phase;

    assign mask      = {cfg_mask_hi, cfg_mask_lo};
    assign adv       = smp_stb && (cfg_simul || smp_ch0);
    assign slot_b    = cfg_alt_en && (phase == PH_B);
    assign scan_step = adv && cfg_scan_en && !slot_b;

    ch0seq_phase_fsm u_phase (
        .clk    (clk),
        .rst    (rst),
        .alt_en (cfg_alt_en),
        .adv    (adv),
        .phase  (phase)
    );

    ch0seq_scan_fsm #(
        .IDX_W  (IDX_W),
        .MASK_W (MASK_W)
    ) u_scan (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (cfg_scan_en),
        .step     (scan_step),
        .restart  (irq_evt),
        .mask     (mask),
        .scan_pos (scan_pos)
    );

    ch0seq_outreg #(
        .IDX_W (IDX_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .slot_b   (slot_b),
        .scan_en  (cfg_scan_en),
        .pos_a    (cfg_pos_a),
        .neg_a    (cfg_neg_a),
        .pos_b    (cfg_pos_b),
        .neg_b    (cfg_neg_b),
        .scan_pos (scan_pos),
        .out_pos  (sel_pos),
        .out_neg  (sel_neg),
        .out_b    (sel_is_b)
    );

endmodule

// File: rtl/ch0seq_checker.sv
module ch0seq_checker #(
    parameter int IDX_W = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic [IDX_W-1:0]        cfg_pos_a,
    input logic                    cfg_neg_a,
    input logic [IDX_W-1:0]        cfg_pos_b,
    input logic                    cfg_neg_b,
    input logic                    cfg_alt_en,
    input logic                    cfg_scan_en,
    input logic                    cfg_simul,
    input logic [(1<<IDX_W)/2-1:0] cfg_mask_hi,
    input logic [(1<<IDX_W)/2-1:0] cfg_mask_lo,
    input logic                    smp_stb,
    input logic                    smp_ch0,
    input logic                    irq_evt,
    input logic [IDX_W-1:0]        sel_pos,
    input logic                    sel_neg,
    input logic                    sel_is_b
);

    localparam int MASK_W = 1 << IDX_W;

    logic              seen_rst = 1'b0;
    logic [1:0]        cyc = 2'd0;
    logic [MASK_W-1:0] m_all;
    logic              adv_in;

    assign m_all  = {cfg_mask_hi, cfg_mask_lo};
    assign adv_in = smp_stb && (cfg_simul || smp_ch0);

    function automatic logic [IDX_W-1:0] first_set(input logic [MASK_W-1:0] m);
        logic [IDX_W-1:0] r;
        logic             hit;
        r   = '0;
        hit = 1'b0;
        for (int i = 0; i < MASK_W; i++) begin
            if (m[i] && !hit) begin
                r   = IDX_W'(i);
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rst <= 1'b1;
            cyc      <= 2'd0;
        end else if (seen_rst && cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R1: fixed mode presents pair A
    assert_fixed_pair_R1: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(!cfg_alt_en && !cfg_scan_en))
        |-> (sel_pos == $past(cfg_pos_a) && sel_neg == $past(cfg_neg_a) && !sel_is_b));

    // R2: an advancing strobe under alternation flips the presented slot
    assert_alt_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(cfg_alt_en) && $past(cfg_alt_en, 2) && $past(adv_in, 2))
        |-> (sel_is_b != $past(sel_is_b)));

    // R6: B slots carry the fixed B pair
    assert_b_slot_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && sel_is_b)
        |-> (sel_pos == $past(cfg_pos_b) && sel_neg == $past(cfg_neg_b)));

    // R5: scanning A slots keep the A negative select
    assert_scan_neg_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(cfg_scan_en) && !sel_is_b)
        |-> (sel_neg == $past(cfg_neg_a)));

    // R8: interrupt restarts the scan at the lowest selected input
    assert_irq_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(irq_evt, 2) && $past(cfg_scan_en) && !sel_is_b
         && $past(m_all) != '0)
        |-> (sel_pos == first_set($past(m_all))));

    // R9: empty mask yields index zero
    assert_empty_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(cfg_scan_en) && $past(m_all) == '0 && !sel_is_b)
        |-> (sel_pos == '0));

endmodule

bind ch0_input_sequencer ch0seq_checker #(.IDX_W(IDX_W)) u_ch0seq_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_pos_a   (cfg_pos_a),
    .cfg_neg_a   (cfg_neg_a),
    .cfg_pos_b   (cfg_pos_b),
    .cfg_neg_b   (cfg_neg_b),
    .cfg_alt_en  (cfg_alt_en),
    .cfg_scan_en (cfg_scan_en),
    .cfg_simul   (cfg_simul),
    .cfg_mask_hi (cfg_mask_hi),
    .cfg_mask_lo (cfg_mask_lo),
    .smp_stb     (smp_stb),
    .smp_ch0     (smp_ch0),
    .irq_evt     (irq_evt),
    .sel_pos     (sel_pos),
    .sel_neg     (sel_neg),
    .sel_is_b    (sel_is_b)
);

// File: tb/test_ch0_input_sequencer.sv
`timescale 1ns/1ps
module test_ch0_input_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cfg_pos_a = '0;
    logic        cfg_neg_a = 1'b0;
    logic [4:0]  cfg_pos_b = '0;
    logic        cfg_neg_b = 1'b0;
    logic        cfg_alt_en = 1'b0;
    logic        cfg_scan_en = 1'b0;
    logic        cfg_simul = 1'b1;
    logic [31:0] mask = '0;
    logic        smp_stb = 1'b0;
    logic        smp_ch0 = 1'b0;
    logic        irq_evt = 1'b0;
    logic [4:0]  sel_pos;
    logic        sel_neg;
    logic        sel_is_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference state
    bit       m_ph;
    bit       m_home;
    int       m_ptr;

    logic [4:0] q_pos[$];
    logic       q_neg[$];
    logic       q_b[$];
    string      q_req[$];
    event       mon_ev;

    always #4 clk = ~clk;

    ch0_input_sequencer i_ch0_input_sequencer (
        .clk         (clk),
        .rst         (rst),
        .cfg_pos_a   (cfg_pos_a),
        .cfg_neg_a   (cfg_neg_a),
        .cfg_pos_b   (cfg_pos_b),
        .cfg_neg_b   (cfg_neg_b),
        .cfg_alt_en  (cfg_alt_en),
        .cfg_scan_en (cfg_scan_en),
        .cfg_simul   (cfg_simul),
        .cfg_mask_hi (mask[31:16]),
        .cfg_mask_lo (mask[15:0]),
        .smp_stb     (smp_stb),
        .smp_ch0     (smp_ch0),
        .irq_evt     (irq_evt),
        .sel_pos     (sel_pos),
        .sel_neg     (sel_neg),
        .sel_is_b    (sel_is_b)
    );

    function automatic int low_of(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic int next_of(input logic [31:0] m, input int x);
        for (int i = x + 1; i < 32; i++) if (m[i]) return i;
        return low_of(m);
    endfunction

    task automatic push(input logic [4:0] p, input logic n, input logic b, input string req);
        q_pos.push_back(p);
        q_neg.push_back(n);
        q_b.push_back(b);
        q_req.push_back(req);
        -> mon_ev;
    endtask

    // expected selection from the reference state
    task automatic check(input string req);
        bit         sb;
        logic [4:0] p;
        logic       n;
        @(negedge clk);
        sb = cfg_alt_en && m_ph;
        if (sb) begin
            p = cfg_pos_b;
            n = cfg_neg_b;
        end else begin
            n = cfg_neg_a;
            if (cfg_scan_en) p = (mask == 0) ? 5'd0 : (m_home ? 5'(low_of(mask)) : 5'(m_ptr));
            else p = cfg_pos_a;
        end
        push(p, n, sb, req);
    endtask

    task automatic step(input bit stb, input bit ch0, input bit irq);
        bit adv;
        bit sb;
        @(negedge clk);
        smp_stb = stb;
        smp_ch0 = ch0;
        irq_evt = irq;
        @(negedge clk);
        smp_stb = 1'b0;
        smp_ch0 = 1'b0;
        irq_evt = 1'b0;
        adv = stb && (cfg_simul || ch0);
        sb  = cfg_alt_en && m_ph;
        if (!cfg_scan_en || irq) begin
            m_home = 1'b1;
        end else if (adv && !sb) begin
            m_ptr  = m_home ? next_of(mask, low_of(mask)) : next_of(mask, m_ptr);
            m_home = 1'b0;
        end
        if (!cfg_alt_en) m_ph = 1'b0;
        else if (adv) m_ph = !m_ph;
    endtask

    // monitor
    initial begin
        forever begin
            @(mon_ev);
            while (q_pos.size() > 0) begin
                logic [4:0] ep;
                logic       en;
                logic       eb;
                string      r;
                ep = q_pos.pop_front();
                en = q_neg.pop_front();
                eb = q_b.pop_front();
                r  = q_req.pop_front();
                checks++;
                if (sel_pos !== ep || sel_neg !== en || sel_is_b !== eb) begin
                    errors++;
                    $display("FAIL %s: pos/neg/b actual %0d/%0d/%0d expected %0d/%0d/%0d",
                             r, sel_pos, sel_neg, sel_is_b, ep, en, eb);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_ph = 0; m_home = 1; m_ptr = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        push(5'd0, 1'b0, 1'b0, "R11 reset");
        @(negedge clk);
        rst = 1'b0;

        // R1: fixed mode
        cfg_pos_a = 5'd7; cfg_neg_a = 1'b1; cfg_pos_b = 5'd12; cfg_neg_b = 1'b0;
        step(0, 0, 0); check("R1 fixed");
        step(1, 1, 0); check("R1 fixed after strobe");
        step(1, 0, 1); check("R1 fixed after irq");

        // R2/R7: alternation, simultaneous
        cfg_alt_en = 1'b1; cfg_simul = 1'b1;
        step(0, 0, 0); check("R2 first slot A");
        step(1, 0, 0); check("R7 simul advances without ch0");
        step(1, 1, 0); check("R2 back to A");
        step(1, 1, 0); check("R2 B again");

        // R7: sequential
        cfg_simul = 1'b0;
        step(1, 0, 0); check("R7 sequential non-ch0 holds");
        step(1, 1, 0); check("R7 sequential ch0 advances");
        step(1, 1, 0); check("R7 sequential ch0 advances again");

        // R10: clearing alternation
        cfg_alt_en = 1'b0;
        step(0, 0, 0); check("R10 alt cleared to A");

        // R3/R4/R5: scanning, inputs 2,5,9,20,31
        cfg_simul = 1'b1; cfg_scan_en = 1'b1; cfg_pos_a = 5'd31;
        mask = 32'h8010_0224;
        step(0, 0, 0); check("R3 scan starts at lowest");
        step(1, 0, 0); check("R4 ascending 5");
        step(1, 0, 0); check("R4 ascending 9");
        step(1, 0, 0); check("R3 high half input 20");
        step(1, 0, 0); check("R3 input 31");
        step(1, 0, 0); check("R4 wrap to lowest");
        cfg_neg_a = 1'b0;
        step(0, 0, 0); check("R5 scan neg from A");

        // R8: interrupt restarts
        step(1, 0, 0); check("R4 at 5");
        step(0, 0, 1); check("R8 irq restart");
        step(1, 0, 0); check("R4 at 5 again");
        step(1, 0, 0); check("R4 at 9");
        step(1, 0, 1); check("R8 irq with strobe");

        // R6: alternation plus scanning
        cfg_alt_en = 1'b1; cfg_neg_b = 1'b1;
        step(0, 0, 0); check("R6 A slot lowest");
        step(1, 0, 0); check("R6 B slot fixed");
        step(1, 0, 0); check("R6 A slot 5");
        step(1, 0, 0); check("R6 B slot fixed again");
        step(1, 0, 0); check("R6 A slot 9");

        // R10: clearing scan returns home
        cfg_alt_en = 1'b0;
        step(0, 0, 0); check("R10 alt cleared");
        cfg_scan_en = 1'b0;
        step(0, 0, 0); check("R10 scan off shows pos_a");
        cfg_scan_en = 1'b1;
        step(0, 0, 0); check("R10 scan back at lowest");

        // R9: empty mask
        mask = '0;
        step(0, 0, 0); check("R9 empty mask");
        step(1, 0, 0); check("R9 empty mask after strobe");

        // R11: reset mid-sequence
        mask = 32'h0000_0224;
        step(1, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        push(5'd0, 1'b0, 1'b0, "R11 reset clears outputs");
        rst = 1'b0;
        m_ph = 0; m_home = 1; m_ptr = 0;
        check("R11 after reset at lowest");

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule